// File: doc/BRIEF.md
# Tagged Two-Stage Byte Holding Pipeline

This block is a pair of one-byte holding stages that join a byte FIFO to a DMA buffer register. Every byte in the pipeline carries a tag flag, so that protocol address codes and run-length codes can travel in the same path as plain data. A direction input selects the flow. In transmit (`txDir` = 1), bytes come from a host register write or from the DMA side and leave stage 2 toward the FIFO. In receive (`txDir` = 0), bytes come from the FIFO side and leave stage 2 toward the DMA buffer.

In receive, an address code enters the pipeline as a tagged byte. That byte stops DMA delivery and raises a host interrupt until the host removes it by reading the stage that holds it. When run-length decoding is enabled, a run-length code bypasses the pipeline and is stored in a count register. In transmit, the host tags a byte by arming a tag bit before it writes stage 1. This works only while automatic DMA is off. A synchronous FIFO reset or the device reset empties both stages.

Top module: `tagHoldPipe`

## Requirements
- R1: After the device reset (`rstN` low) or a one-cycle `fifoReset` pulse, `hrStatus` is 0, `irq` is 0 and both stage data outputs read 0x00.
- R2: Bytes always enter stage 1, move to stage 2, and leave stage 2 in the order they were accepted.
- R3: Stage 1 advances only when stage 2 is empty or is drained in the same cycle. While both stages are full and stage 2 is not drained, stage 1 keeps its byte and the input-side ready (`dmaInReady` or `fifoInReady`) is 0.
- R4: In receive, with DMA enabled and no tagged byte present, the untagged byte in stage 2 is offered on `dmaOutValid`/`outData` and leaves when `dmaOutReady` is 1.
- R5: In receive, a byte marked `fifoInIsRle` while `rleEnable` is 1 is accepted and goes into `rlCount` at the next edge, and the stages do not change. While `rleEnable` is 0, the same byte enters stage 1 as a tagged byte.
- R6: In receive, while any stage holds a tagged byte, `irq` is 1 and `dmaOutValid` is 0. A host read pulse (`hostRd1` or `hostRd2`) removes that stage's byte and its tag.
- R7: A control write (`ctrlWr`) loads the DMA-enable and tag-arm bits together. A host write to stage 1 in transmit, accepted while armed and with DMA disabled, stores the byte tagged and disarms the tag (`tagArmed` goes to 0). The next write stores an untagged byte.
- R8: A host write accepted while armed but with DMA enabled stores the byte untagged and leaves `tagArmed` at 1.
- R9: `hrStatus` bit 0 is stage 1 valid, bit 1 is stage 1 tag, bit 2 is stage 2 valid, and bit 3 is stage 2 tag.
- R10: In transmit, `irq` stays 0 even when tagged bytes are held.
- R11: In transmit, a host write to stage 1 has priority over the DMA input. `dmaInReady` is 0 in any cycle with `hostWr1` asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Device reset, active low, asynchronous |
| fifoReset | input | 1 | Synchronous clear of both stages and tags |
| txDir | input | 1 | 1 = transmit (toward FIFO), 0 = receive |
| rleEnable | input | 1 | Divert received run-length codes to `rlCount` |
| ctrlWr | input | 1 | Control write strobe |
| ctrlSetTag | input | 1 | Tag-arm value loaded by `ctrlWr` |
| ctrlDmaEn | input | 1 | DMA-enable value loaded by `ctrlWr` |
| tagArmed | output | 1 | Tag-arm bit state |
| hostWr1 | input | 1 | Host write to stage 1 (transmit) |
| hostWrData | input | 8 | Host write byte |
| hostRd1 | input | 1 | Host read-and-remove of stage 1 |
| hostRd2 | input | 1 | Host read-and-remove of stage 2 |
| stg1Data | output | 8 | Stage 1 byte |
| stg2Data | output | 8 | Stage 2 byte |
| hrStatus | output | 4 | {tag2, valid2, tag1, valid1} |
| irq | output | 1 | Host interrupt for a held tagged byte in receive |
| dmaInValid | input | 1 | DMA side offers a byte (transmit) |
| dmaInData | input | 8 | DMA side byte |
| dmaInReady | output | 1 | DMA side byte accepted |
| fifoInValid | input | 1 | FIFO side offers a byte (receive) |
| fifoInData | input | 8 | FIFO side byte |
| fifoInTag | input | 1 | FIFO byte is an address code |
| fifoInIsRle | input | 1 | FIFO byte is a run-length code |
| fifoInReady | output | 1 | FIFO side byte accepted |
| fifoOutValid | output | 1 | Stage 2 byte offered to FIFO (transmit) |
| fifoOutReady | input | 1 | FIFO takes the byte |
| dmaOutValid | output | 1 | Stage 2 byte offered to DMA buffer (receive) |
| dmaOutReady | input | 1 | DMA buffer takes the byte |
| outData | output | 8 | Stage 2 byte on the outgoing side |
| outTag | output | 1 | Stage 2 tag on the outgoing side |
| rlCount | output | 8 | Captured run-length count |

## Verification
The hardest state to reach is a receive pipeline with an untagged byte stalled in stage 2 behind the DMA side and a tagged address in stage 1. In that state the interrupt must come from stage 1 while stage 2 is blocked. The bench reaches it by holding `dmaOutReady` low, feeding a plain byte and then an address code, and then removing the address with a stage 1 read. A second sequence puts the tagged byte in stage 2 with a plain byte behind it. It checks that a stage 2 read lets the plain byte advance at the same edge.

// File: rtl/tagHoldPipe_pkg.sv
package tagHoldPipe_pkg;
  typedef enum logic [1:0] {
    SRC_HOST = 2'd0,
    SRC_DMA  = 2'd1,
    SRC_FIFO = 2'd2
  } srcSel_e;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic    clear;
    logic    load1;
    srcSel_e src;
    logic    advance;
    logic    loadRl;
  } stageStrobe_t;
endpackage

// File: rtl/tagHoldCtrl.sv
module tagHoldCtrl
  import tagHoldPipe_pkg::*;
#(
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoReset,
  input  logic              txDir,
  input  logic              rleEnable,
  input  logic              ctrlWr,
  input  logic              ctrlSetTag,
  input  logic              ctrlDmaEn,
  input  logic              hostWr1,
  input  logic              hostRd1,
  input  logic              hostRd2,
  input  logic              dmaInValid,
  input  logic              fifoInValid,
  input  logic              fifoInTag,
  input  logic              fifoInIsRle,
  input  logic              fifoOutReady,
  input  logic              dmaOutReady,
  output stageStrobe_t      strb,
  output logic              tagArmed,
  output logic              dmaInReady,
  output logic              fifoInReady,
  output logic              fifoOutValid,
  output logic              dmaOutValid,
  output logic              outTag,
  output logic              irq,
  output logic [STAT_W-1:0] hrStatus
);
  logic v1, t1, v2, t2;
  logic dmaEn, armed;
  logic anyTag, drain2, pop1, advance, free1;
  logic hostLoad, dmaLoad, fifoLoad, rleHit, load1, newTag;

  always_comb begin
    anyTag       = (v1 & t1) | (v2 & t2);
    fifoOutValid = txDir & v2;
    dmaOutValid  = ~txDir & v2 & dmaEn & ~anyTag;
    drain2       = v2 & ((fifoOutValid & fifoOutReady) |
                         (dmaOutValid & dmaOutReady) | hostRd2);
    pop1         = v1 & hostRd1;
    advance      = v1 & ~hostRd1 & (~v2 | drain2);
    free1        = ~v1 | advance | pop1;
    hostLoad     = txDir & hostWr1 & free1;
    dmaInReady   = txDir & dmaEn & free1 & ~hostWr1;
    dmaLoad      = dmaInValid & dmaInReady;
    rleHit       = fifoInIsRle & rleEnable;
    fifoInReady  = ~txDir & (rleHit | free1);
    fifoLoad     = ~txDir & fifoInValid & ~rleHit & free1;
    load1        = hostLoad | dmaLoad | fifoLoad;
    if (hostLoad)      newTag = armed & ~dmaEn;
    else if (fifoLoad) newTag = fifoInTag | fifoInIsRle;
    else               newTag = 1'b0;

    strb.clear   = fifoReset;
    strb.load1   = load1;
    strb.src     = hostLoad ? SRC_HOST : (dmaLoad ? SRC_DMA : SRC_FIFO);
    strb.advance = advance;
    strb.loadRl  = ~txDir & fifoInValid & rleHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1 <= 1'b0; t1 <= 1'b0; v2 <= 1'b0; t2 <= 1'b0;
    end else if (fifoReset) begin
      v1 <= 1'b0; t1 <= 1'b0; v2 <= 1'b0; t2 <= 1'b0;
    end else begin
      if (advance) begin
        v2 <= 1'b1; t2 <= t1;
      end else if (drain2) begin
        v2 <= 1'b0; t2 <= 1'b0;
      end
      if (load1) begin
        v1 <= 1'b1; t1 <= newTag;
      end else if (advance | pop1) begin
        v1 <= 1'b0; t1 <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmaEn <= 1'b0;
      armed <= 1'b0;
    end else if (ctrlWr) begin
      dmaEn <= ctrlDmaEn;
      armed <= ctrlSetTag;
    end else if (hostLoad & armed & ~dmaEn) begin
      armed <= 1'b0;
    end
  end

  assign tagArmed = armed;
  assign outTag   = t2;
  assign irq      = ~txDir & anyTag;
  assign hrStatus = {t2, v2, t1, v1};
endmodule

// File: rtl/tagHoldData.sv
module tagHoldData
  import tagHoldPipe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  stageStrobe_t      strb,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [DATA_W-1:0] dmaInData,
  input  logic [DATA_W-1:0] fifoInData,
  output logic [DATA_W-1:0] stg1Data,
  output logic [DATA_W-1:0] stg2Data,
  output logic [DATA_W-1:0] rlCount
);
  logic [DATA_W-1:0] inByte;

  always_comb begin
    case (strb.src)
      SRC_HOST: inByte = hostWrData;
      SRC_DMA:  inByte = dmaInData;
      default:  inByte = fifoInData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stg1Data <= '0;
      stg2Data <= '0;
    end else if (strb.clear) begin
      stg1Data <= '0;
      stg2Data <= '0;
    end else begin
      if (strb.advance) stg2Data <= stg1Data;
      if (strb.load1)   stg1Data <= inByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rlCount <= '0;
    else if (strb.loadRl) rlCount <= fifoInData;
  end
endmodule

// File: rtl/tagHoldPipe.sv
module tagHoldPipe
  import tagHoldPipe_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoReset,
  input  logic              txDir,
  input  logic              rleEnable,
  input  logic              ctrlWr,
  input  logic              ctrlSetTag,
  input  logic              ctrlDmaEn,
  output logic              tagArmed,
  input  logic              hostWr1,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostRd1,
  input  logic              hostRd2,
  output logic [DATA_W-1:0] stg1Data,
  output logic [DATA_W-1:0] stg2Data,
  output logic [STAT_W-1:0] hrStatus,
  output logic              irq,
  input  logic              dmaInValid,
  input  logic [DATA_W-1:0] dmaInData,
  output logic              dmaInReady,
  input  logic              fifoInValid,
  input  logic [DATA_W-1:0] fifoInData,
  input  logic              fifoInTag,
  input  logic              fifoInIsRle,
  output logic              fifoInReady,
  output logic              fifoOutValid,
  input  logic              fifoOutReady,
  output logic              dmaOutValid,
  input  logic              dmaOutReady,
  output logic [DATA_W-1:0] outData,
  output logic              outTag,
  output logic [DATA_W-1:0] rlCount
);
  stageStrobe_t strb;

  tagHoldCtrl #(.STAT_W(STAT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .fifoReset(fifoReset), .txDir(txDir),
    .rleEnable(rleEnable), .ctrlWr(ctrlWr), .ctrlSetTag(ctrlSetTag),
    .ctrlDmaEn(ctrlDmaEn), .hostWr1(hostWr1), .hostRd1(hostRd1),
    .hostRd2(hostRd2), .dmaInValid(dmaInValid), .fifoInValid(fifoInValid),
    .fifoInTag(fifoInTag), .fifoInIsRle(fifoInIsRle),
    .fifoOutReady(fifoOutReady), .dmaOutReady(dmaOutReady), .strb(strb),
    .tagArmed(tagArmed), .dmaInReady(dmaInReady), .fifoInReady(fifoInReady),
    .fifoOutValid(fifoOutValid), .dmaOutValid(dmaOutValid),
    .outTag(outTag), .irq(irq), .hrStatus(hrStatus)
  );

  tagHoldData #(.DATA_W(DATA_W)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .hostWrData(hostWrData),
    .dmaInData(dmaInData), .fifoInData(fifoInData), .stg1Data(stg1Data),
    .stg2Data(stg2Data), .rlCount(rlCount)
  );

  assign outData = stg2Data;
endmodule

// File: rtl/tagHoldPipe_chk.sv
module tagHoldPipe_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              fifoReset,
  input logic              txDir,
  input logic              rleEnable,
  input logic              ctrlWr,
  input logic              hostWr1,
  input logic              hostRd1,
  input logic              hostRd2,
  input logic              tagArmed,
  input logic [DATA_W-1:0] stg1Data,
  input logic [3:0]        hrStatus,
  input logic              irq,
  input logic              fifoInValid,
  input logic [DATA_W-1:0] fifoInData,
  input logic              fifoInIsRle,
  input logic              fifoOutValid,
  input logic              fifoOutReady,
  input logic              dmaOutValid,
  input logic              dmaOutReady,
  input logic [DATA_W-1:0] outData,
  input logic [DATA_W-1:0] rlCount
);
  p_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    fifoReset |=> (hrStatus == 4'b0000 && !irq));

  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fifoOutValid && !fifoOutReady && !hostRd2 && !fifoReset) |=> $stable(outData));

  p_backpress_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hrStatus[0] && hrStatus[2] && !fifoReset && !hostRd1 && !hostRd2 &&
     !(fifoOutValid && fifoOutReady) && !(dmaOutValid && dmaOutReady))
    |=> ($stable(stg1Data) && hrStatus[0]));

  p_rle_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!txDir && rleEnable && fifoInValid && fifoInIsRle)
    |=> (rlCount == $past(fifoInData)));

  p_tag_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!txDir && (hrStatus[1] || hrStatus[3])) |-> !dmaOutValid);

  p_arm_steady_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlWr && !hostWr1) |=> $stable(tagArmed));

  p_no_tx_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    txDir |-> !irq);
endmodule

bind tagHoldPipe tagHoldPipe_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rstN(rstN), .fifoReset(fifoReset), .txDir(txDir),
  .rleEnable(rleEnable), .ctrlWr(ctrlWr), .hostWr1(hostWr1),
  .hostRd1(hostRd1), .hostRd2(hostRd2), .tagArmed(tagArmed),
  .stg1Data(stg1Data), .hrStatus(hrStatus), .irq(irq),
  .fifoInValid(fifoInValid), .fifoInData(fifoInData),
  .fifoInIsRle(fifoInIsRle), .fifoOutValid(fifoOutValid),
  .fifoOutReady(fifoOutReady), .dmaOutValid(dmaOutValid),
  .dmaOutReady(dmaOutReady), .outData(outData), .rlCount(rlCount)
);

// File: tb/test_tagHoldPipe.sv
`timescale 1ns/1ps
module test_tagHoldPipe;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoReset = 0, txDir = 1, rleEnable = 0;
  logic ctrlWr = 0, ctrlSetTag = 0, ctrlDmaEn = 0;
  logic tagArmed;
  logic hostWr1 = 0, hostRd1 = 0, hostRd2 = 0;
  logic [7:0] hostWrData = 0;
  logic [7:0] stg1Data, stg2Data, outData, rlCount;
  logic [3:0] hrStatus;
  logic irq, dmaInReady, fifoInReady, fifoOutValid, dmaOutValid, outTag;
  logic dmaInValid = 0, fifoInValid = 0, fifoInTag = 0, fifoInIsRle = 0;
  logic [7:0] dmaInData = 0, fifoInData = 0;
  logic fifoOutReady = 0, dmaOutReady = 0;

  int nChecks = 0, nFail = 0;
  logic [7:0] txq [16];
  logic [7:0] rxq [16];
  int txCnt = 0, rxCnt = 0;

  always #2.5 clk = ~clk;

  tagHoldPipe i_tagHoldPipe (.*);

  always @(posedge clk) begin
    if (fifoOutValid && fifoOutReady && txCnt < 16) begin
      txq[txCnt] <= outData; txCnt <= txCnt + 1;
    end
    if (dmaOutValid && dmaOutReady && rxCnt < 16) begin
      rxq[rxCnt] <= outData; rxCnt <= rxCnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic ctrlWrite(input logic setTag, input logic dmaOn);
    ctrlWr = 1; ctrlSetTag = setTag; ctrlDmaEn = dmaOn;
    tick(1);
    ctrlWr = 0;
  endtask

  task automatic hostWrite(input logic [7:0] d);
    hostWr1 = 1; hostWrData = d;
    tick(1);
    hostWr1 = 0;
  endtask

  task automatic pushDma(input logic [7:0] d);
    dmaInValid = 1; dmaInData = d;
    forever begin
      @(negedge clk);
      if (dmaInReady) begin tick(1); break; end
    end
    dmaInValid = 0;
  endtask

  task automatic pushFifo(input logic [7:0] d, input logic tg, input logic rle);
    fifoInValid = 1; fifoInData = d; fifoInTag = tg; fifoInIsRle = rle;
    forever begin
      @(negedge clk);
      if (fifoInReady) begin tick(1); break; end
    end
    fifoInValid = 0; fifoInTag = 0; fifoInIsRle = 0;
  endtask

  task automatic pulseFifoReset();
    fifoReset = 1; tick(1); fifoReset = 0;
  endtask

  task automatic t_reset();
    check(hrStatus == 4'b0000, "R1 reset status", hrStatus, 0);
    check(irq == 1'b0, "R1 reset irq", irq, 0);
    check(stg1Data == 8'h00 && stg2Data == 8'h00, "R1 reset data", {stg2Data, stg1Data}, 0);
  endtask

  task automatic t_txOrder();
    txDir = 1; fifoOutReady = 0;
    ctrlWrite(1'b0, 1'b1);
    pushDma(8'h11);
    pushDma(8'h22);
    check(hrStatus == 4'b0101, "R9 both valid untagged", hrStatus, 4'b0101);
    check(stg1Data == 8'h22 && outData == 8'h11, "R2 stage order", {outData, stg1Data}, 16'h1122);
    dmaInValid = 1; dmaInData = 8'h33;
    tick(2);
    check(dmaInReady == 1'b0, "R3 ready low when full", dmaInReady, 0);
    check(stg1Data == 8'h22 && hrStatus[0], "R3 stage 1 held", stg1Data, 8'h22);
    dmaInValid = 0;
    fifoOutReady = 1;
    pushDma(8'h33);
    pushDma(8'h44);
    tick(4);
    check(txCnt == 4, "R2 count out", txCnt, 4);
    check(txq[0] == 8'h11 && txq[1] == 8'h22 && txq[2] == 8'h33 && txq[3] == 8'h44,
          "R2 order out", {txq[0], txq[1], txq[2], txq[3]}, 32'h11223344);
    hostWr1 = 1; hostWrData = 8'h55; dmaInValid = 1; dmaInData = 8'h66;
    @(negedge clk);
    check(dmaInReady == 1'b0, "R11 host priority", dmaInReady, 0);
    tick(1);
    hostWr1 = 0;
    pushDma(8'h66);
    tick(4);
    check(txq[4] == 8'h55 && txq[5] == 8'h66, "R11 host byte first", {txq[4], txq[5]}, 16'h5566);
    fifoOutReady = 0;
  endtask

  task automatic t_txTag();
    txDir = 1; fifoOutReady = 0;
    ctrlWrite(1'b1, 1'b0);
    check(tagArmed == 1'b1, "R7 armed by control write", tagArmed, 1);
    hostWrite(8'hA5);
    check(hrStatus == 4'b0011, "R7 tagged write", hrStatus, 4'b0011);
    check(tagArmed == 1'b0, "R7 self-disarm", tagArmed, 0);
    check(irq == 1'b0, "R10 no irq in transmit", irq, 0);
    tick(1);
    check(hrStatus == 4'b1100, "R9 tag in stage 2", hrStatus, 4'b1100);
    hostWrite(8'h5A);
    check(hrStatus == 4'b1101, "R7 next write untagged", hrStatus, 4'b1101);
    check(outTag == 1'b1 && outData == 8'hA5, "R7 tagged byte out", {outTag, outData}, 9'h1A5);
    check(irq == 1'b0, "R10 no irq with tag held", irq, 0);
    fifoOutReady = 1; tick(3); fifoOutReady = 0;
    ctrlWrite(1'b1, 1'b1);
    hostWrite(8'h77);
    check(hrStatus == 4'b0001, "R8 untagged with DMA on", hrStatus, 4'b0001);
    check(tagArmed == 1'b1, "R8 stays armed", tagArmed, 1);
    ctrlWrite(1'b0, 1'b0);
    pulseFifoReset();
    check(hrStatus == 4'b0000, "R1 fifo reset clears", hrStatus, 0);
  endtask

  task automatic t_rx();
    txDir = 0; rleEnable = 1; dmaOutReady = 1;
    ctrlWrite(1'b0, 1'b1);
    pushFifo(8'h31, 1'b0, 1'b0);
    tick(3);
    check(rxCnt == 1 && rxq[0] == 8'h31, "R4 untagged to DMA", rxq[0], 8'h31);
    pushFifo(8'h07, 1'b0, 1'b1);
    check(rlCount == 8'h07, "R5 run-length captured", rlCount, 8'h07);
    check(hrStatus == 4'b0000, "R5 pipeline untouched", hrStatus, 0);
    pushFifo(8'h9C, 1'b1, 1'b0);
    check(hrStatus == 4'b0011 && irq, "R6 tagged raises irq", {irq, hrStatus}, 5'h13);
    pushFifo(8'h42, 1'b0, 1'b0);
    tick(2);
    check(hrStatus == 4'b1101, "R6 tag in stage 2", hrStatus, 4'b1101);
    check(dmaOutValid == 1'b0 && rxCnt == 1, "R6 DMA stalled", dmaOutValid, 0);
    check(stg2Data == 8'h9C, "R6 host sees address", stg2Data, 8'h9C);
    hostRd2 = 1; tick(1); hostRd2 = 0;
    check(hrStatus == 4'b0100 && !irq, "R6 read stage 2 clears", hrStatus, 4'b0100);
    tick(1);
    check(rxCnt == 2 && rxq[1] == 8'h42, "R4 resumes after read", rxq[1], 8'h42);
    dmaOutReady = 0;
    pushFifo(8'h50, 1'b0, 1'b0);
    pushFifo(8'hA1, 1'b1, 1'b0);
    check(hrStatus == 4'b0111 && irq, "R6 tag in stage 1 behind data", hrStatus, 4'b0111);
    check(stg1Data == 8'hA1, "R6 host sees stage 1", stg1Data, 8'hA1);
    hostRd1 = 1; tick(1); hostRd1 = 0;
    check(hrStatus == 4'b0100 && !irq, "R6 read stage 1 clears", hrStatus, 4'b0100);
    dmaOutReady = 1; tick(2);
    check(rxq[2] == 8'h50, "R4 delivered after read", rxq[2], 8'h50);
    rleEnable = 0;
    pushFifo(8'h05, 1'b0, 1'b1);
    check(hrStatus == 4'b0011 && irq, "R5 disabled enters tagged", hrStatus, 4'b0011);
    check(rlCount == 8'h07, "R5 count unchanged", rlCount, 8'h07);
    pulseFifoReset();
    check(hrStatus == 4'b0000 && !irq, "R1 fifo reset clears tag", hrStatus, 0);
    check(stg1Data == 8'h00 && stg2Data == 8'h00, "R1 fifo reset data", {stg2Data, stg1Data}, 0);
  endtask

  initial begin
    #100000;
    nChecks++; nFail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    rstN = 1;
    tick(2);
    t_reset();
    t_txOrder();
    t_txTag();
    t_rx();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule